// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches up to sixteen general-purpose input pins (twelve by default) and turns selected transitions or levels on them into pending interrupt bits. Each pin passes through a two-flop synchroniser. A per-channel trigger code then decides what counts as an event: a rising edge, a falling edge, either edge, a high level or a low level. An event on an enabled channel sets that channel's pending bit. Software clears a pending bit by writing a one to that bit of the acknowledge address.

A mask register gates pending bits away from the single combined interrupt line. The mask does not stop bits from being recorded. Software changes the mask only through a set port and a clear port, which both take write-one semantics, and it can read the mask back. The enable register is a separate register. It decides whether a channel can become pending at all.

All registers sit on a plain single-cycle write strobe with an address and a combinational read-data bus. The addresses are 3 bits wide and the data is 32 bits wide.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable, mask, pending and both trigger-code registers read zero, and `irq_o` is low.
- R2: Trigger code 1 sets the pending bit on a low-to-high transition of the synchronised pin and not on a high-to-low one.
- R3: Trigger code 0 sets the pending bit on a high-to-low transition of the synchronised pin and not on a low-to-high one.
- R4: Trigger code 4 sets the pending bit on either transition.
- R5: Trigger codes 3 (high) and 2 (low) keep the pending bit set while the level is present, so an acknowledge has no effect until the level goes away.
- R6: Trigger codes 5, 6 and 7 never set a pending bit, for any pin activity.
- R7: A channel whose enable bit is 0 never becomes pending, and enabling it later does not replay an edge that has already passed.
- R8: Writing to the acknowledge address clears exactly the pending bits written as 1; bits written as 0 leave their pending bits unchanged.
- R9: Writing a 1 to the mask-set address masks that channel, and writing a 1 to the mask-clear address unmasks it. The mask reads back at its own address, and masking never alters the pending bits.
- R10: `irq_o` is high exactly when some channel is both pending and unmasked.
- R11: The trigger code of channel n is 3 bits at bit 4n of trigger register 0 for n < 8, and at bit 4(n-8) of trigger register 1 for n >= 8. Bit 3 of each nibble is stored but ignored.
- R12: When an event and an acknowledge of the same channel fall in the same cycle, the pending bit stays set.
- R13: The address map is 0 enable (read/write), 1 mask (read), 2 mask-set, 3 mask-clear, 4 pending (read), 5 acknowledge, 6 trigger register 0 (read/write), 7 trigger register 1 (read/write). Write-only addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | N_CH | Raw, asynchronous input pins |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt: some channel pending and unmasked |

## Verification
The bench builds the block with its default of twelve channels. With twelve channels, channels 8 to 11 take their trigger codes from the second trigger register, so the bench can check the split lookup across both registers. It also leaves nibbles of that register unused, and those must still read back intact. Every trigger code from 0 to 7 is applied to a live pin. The bench checks level persistence against acknowledge, and mask gating with the pending bits left untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam logic [AW-1:0] A_EN    = 3'd0;
  localparam logic [AW-1:0] A_MASK  = 3'd1;
  localparam logic [AW-1:0] A_MSET  = 3'd2;
  localparam logic [AW-1:0] A_MCLR  = 3'd3;
  localparam logic [AW-1:0] A_STAT  = 3'd4;
  localparam logic [AW-1:0] A_ACK   = 3'd5;
  localparam logic [AW-1:0] A_MODE0 = 3'd6;
  localparam logic [AW-1:0] A_MODE1 = 3'd7;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic [2:0] mode_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise = sig_i & ~prev_q;
  assign fall = ~sig_i & prev_q;

  always_comb begin
    unique case (mode_i)
      TRIG_FALL: hit_o = fall;
      TRIG_RISE: hit_o = rise;
      TRIG_LOW:  hit_o = ~sig_i;
      TRIG_HIGH: hit_o = sig_i;
      TRIG_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;  // reserved codes
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_CH = 12  // 1..16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] gpio_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int unsigned LO_CH = 8;

  logic [N_CH-1:0] en_q, mask_q, status_q;
  logic [DW-1:0]   mode0_q, mode1_q;
  logic [N_CH-1:0] pin_s, hit;
  logic [N_CH-1:0] wd, ack_v, mset_v, mclr_v;

  gpio_irq_sync #(.W(N_CH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [2:0] mode;
    if (g < LO_CH) begin : g_lo
      assign mode = mode0_q[4*g +: 3];
    end else begin : g_hi
      assign mode = mode1_q[4*(g-LO_CH) +: 3];
    end
    gpio_irq_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (pin_s[g]),
      .mode_i(mode),
      .hit_o (hit[g])
    );
  end

  assign wd     = wdata_i[N_CH-1:0];
  assign ack_v  = (we_i && addr_i == A_ACK)  ? wd : '0;
  assign mset_v = (we_i && addr_i == A_MSET) ? wd : '0;
  assign mclr_v = (we_i && addr_i == A_MCLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      mask_q   <= '0;
      status_q <= '0;
      mode0_q  <= '0;
      mode1_q  <= '0;
    end else begin
      if (we_i && addr_i == A_EN)    en_q    <= wd;
      if (we_i && addr_i == A_MODE0) mode0_q <= wdata_i;
      if (we_i && addr_i == A_MODE1) mode1_q <= wdata_i;
      mask_q   <= (mask_q & ~mclr_v) | mset_v;
      // set wins over acknowledge
      status_q <= (hit & en_q) | (status_q & ~ack_v);
    end
  end

  always_comb begin
    unique case (addr_i)
      A_EN:    rdata_o = DW'(en_q);
      A_MASK:  rdata_o = DW'(mask_q);
      A_STAT:  rdata_o = DW'(status_q);
      A_MODE0: rdata_o = mode0_q;
      A_MODE1: rdata_o = mode1_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_CH = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [N_CH-1:0] wd,
  input logic            irq_o,
  input logic [N_CH-1:0] en_q,
  input logic [N_CH-1:0] mask_q,
  input logic [N_CH-1:0] status_q
);
  logic [N_CH-1:0] c_ack, c_set, c_clr;
  assign c_ack = (we_i && addr_i == A_ACK)  ? wd : '0;
  assign c_set = (we_i && addr_i == A_MSET) ? wd : '0;
  assign c_clr = (we_i && addr_i == A_MCLR) ? wd : '0;

  p_no_pend_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  p_clear_only_acked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~status_q & $past(status_q) & ~$past(c_ack)) == '0));

  p_mask_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|c_set) |=> ((mask_q & $past(c_set)) == $past(c_set)));

  p_mask_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|c_clr) |=> ((mask_q & $past(c_clr)) == '0));

  p_all_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wd      (wd),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .mask_q  (mask_q),
  .status_q(status_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 12;
  localparam logic [31:0] MODE_LO = 32'h0152_3401;  // ch0..7: 1,0,4,3,2,5,1,0

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N_CH-1:0] gpio = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] en_sh = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.N_CH(N_CH)) u_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle;
    repeat (4) @(negedge clk);
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk);
    gpio[n] = v;
    settle();
  endtask

  task automatic enable(input int n);
    en_sh[n] = 1'b1;
    wr(3'd0, en_sh);
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(3'd4, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset addr %0d", a), d, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(3'd6, MODE_LO);
    rd(3'd6, d);
    chk("R13 mode0 readback", d, MODE_LO);
    enable(0);
    rd(3'd0, d);
    chk("R13 enable readback", d, 32'h1);
    pin(0, 1'b1);
    chk_stat("R2 rise sets", 32'h1);
    chk("R10 irq on pending", {31'h0, irq}, 32'h1);
    wr(3'd5, 32'h1);
    chk_stat("R8 ack clears", 32'h0);
    chk("R10 irq low after ack", {31'h0, irq}, 32'h0);
    pin(0, 1'b0);
    chk_stat("R2 fall ignored", 32'h0);
  endtask

  task automatic t_fall;
    enable(1);
    pin(1, 1'b1);
    chk_stat("R3 rise ignored", 32'h0);
    pin(1, 1'b0);
    chk_stat("R3 fall sets", 32'h2);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_both;
    enable(2);
    pin(2, 1'b1);
    chk_stat("R4 rise sets", 32'h4);
    wr(3'd5, 32'h4);
    chk_stat("R4 cleared", 32'h0);
    pin(2, 1'b0);
    chk_stat("R4 fall sets", 32'h4);
    wr(3'd5, 32'h4);
  endtask

  task automatic t_level;
    enable(3);
    pin(3, 1'b1);
    chk_stat("R5 high sets", 32'h8);
    wr(3'd5, 32'h8);
    chk_stat("R5 high persists after ack", 32'h8);
    pin(3, 1'b0);
    wr(3'd5, 32'h8);
    chk_stat("R5 high gone clears", 32'h0);
    enable(4);
    settle();
    chk_stat("R5 low sets", 32'h10);
    wr(3'd5, 32'h10);
    chk_stat("R5 low persists", 32'h10);
    pin(4, 1'b1);
    wr(3'd5, 32'h10);
    chk_stat("R5 low gone clears", 32'h0);
  endtask

  task automatic t_reserved;
    enable(5);
    pin(5, 1'b1);
    chk_stat("R6 code5 rise/high", 32'h0);
    pin(5, 1'b0);
    chk_stat("R6 code5 fall/low", 32'h0);
    wr(3'd6, (MODE_LO & ~32'h00F0_0000) | 32'h0060_0000);
    pin(5, 1'b1);
    chk_stat("R6 code6", 32'h0);
    wr(3'd6, (MODE_LO & ~32'h00F0_0000) | 32'h0070_0000);
    pin(5, 1'b0);
    chk_stat("R6 code7", 32'h0);
    wr(3'd6, MODE_LO);
  endtask

  task automatic t_disabled;
    pin(6, 1'b1);
    chk_stat("R7 disabled rise", 32'h0);
    chk("R7 irq quiet", {31'h0, irq}, 32'h0);
    enable(6);
    settle();
    chk_stat("R7 no replay", 32'h0);
  endtask

  task automatic t_hi_bank;
    logic [31:0] d;
    wr(3'd7, 32'hA000_0010);  // ch8 code0, ch9 code1, unused nibble kept
    rd(3'd7, d);
    chk("R11 mode1 readback", d, 32'hA000_0010);
    enable(8);
    enable(9);
    pin(9, 1'b1);
    pin(8, 1'b1);
    chk_stat("R11 ch9 rise, ch8 rise ignored", 32'h200);
  endtask

  task automatic t_mask_ack;
    logic [31:0] d;
    wr(3'd2, 32'h200);
    rd(3'd1, d);
    chk("R9 mask set readback", d, 32'h200);
    chk("R10 masked irq low", {31'h0, irq}, 32'h0);
    chk_stat("R9 mask keeps pending", 32'h200);
    rd(3'd2, d);
    chk("R13 write-only reads zero", d, 32'h0);
    wr(3'd3, 32'h200);
    rd(3'd1, d);
    chk("R9 mask clear readback", d, 32'h0);
    chk("R10 unmasked irq high", {31'h0, irq}, 32'h1);
    wr(3'd5, 32'h001);
    chk_stat("R8 zero bits no effect", 32'h200);
    wr(3'd5, 32'h200);
    chk_stat("R8 ack ch9", 32'h0);
    pin(8, 1'b0);
    chk_stat("R11 ch8 fall from reg1", 32'h100);
    wr(3'd5, 32'h100);
  endtask

  task automatic t_priority;
    pin(3, 1'b1);
    wr(3'd5, 32'h8);
    chk_stat("R12 set beats ack", 32'h8);
    pin(3, 1'b0);
    wr(3'd5, 32'h8);
    chk_stat("R12 clear once set gone", 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_reserved();
    t_disabled();
    t_hi_bank();
    t_mask_ack();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule